// File: doc/BRIEF.md
# Register-Controlled PWM Generator with Dead Time

This block drives a complementary pair of switch outputs, a high side and a low side, from a fixed-period pulse-width modulator. A processor programs the block with one packed control word. Its low field is the on-time, and its upper field is the dead time in clock cycles. The word can be written in one access, or one field at a time through byte-lane style strobes. A free-running counter divides time into periods of 256 cycles. The raw pulse is compared against the on-time. The dead-time stage then holds off each output's rising edge until the raw pulse has settled for the programmed number of cycles, so the two sides are never on together.

Settings written at any point in a period are held in a live register. They are copied into shadow registers only at the end of the period, so each period runs with one consistent pair of on-time and dead time. The register port is a plain synchronous write port with an address, a write enable, two lane strobes and the data word.

Top module: `pwmdt_gen`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. It clears the period counter and the live, shadow and pipeline registers. Both outputs are low while reset is held, and also in the first cycle after it is released.
- R2: A write with `wr_en` high and `wr_addr` equal to `REG_ADDR` (default 0) updates the live fields. `wr_strb[0]` loads the on-time from `wr_data[7:0]`, and `wr_strb[1]` loads the dead time from `wr_data[11:8]`. Both strobes update both fields in one access, and a field whose strobe is low keeps its value.
- R3: A write to any other address changes neither field.
- R4: The period is 256 cycles. For on-time D, the raw pulse is high in phases 0..D-1 of each period, so D = 0 never turns the high side on. D = 255 keeps the raw pulse high for the whole period. The outputs follow the phase compare two clock cycles later.
- R5: The high side rises only once the raw pulse has been high for the programmed dead time T, measured in cycles. This leaves T cycles with both outputs low after the low side falls.
- R6: The low side rises only once the raw pulse has been low for T cycles. This leaves T cycles with both outputs low after the high side falls.
- R7: The high and low outputs are never high in the same cycle, for any setting.
- R8: New settings take effect only at a period boundary, when the counter wraps from 255 to 0. A write during a period does not alter the period in progress.
- R9: With a dead time of 0, the two outputs are exact complements in every cycle after the first cycle following reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_strb | input | 2 | Lane strobes: bit 0 for on-time, bit 1 for dead time |
| wr_data | input | DUTY_W+DEAD_W (12) | Packed control word |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |

## Verification
The assertions assume that reset is held for at least one clock edge before any settings are written. They also assume that the write-port inputs change only away from the active edge; the pulse shape itself places no limit on the settings. The stimulus starts and re-enters reset through a held low pulse on `rst_n`, and it drives every write at the falling edge. Within those limits it covers all on-time and dead-time values, writes landing mid-period and on the wrap edge, partial-lane writes and writes to foreign addresses.

// File: rtl/pwmdt_pkg.sv
// Shared constants for the dead-time PWM block.
// Assumes: the two fields of the control word map to two write lanes.
package pwmdt_pkg;
    localparam int unsigned DEF_DUTY_W   = 8;
    localparam int unsigned DEF_DEAD_W   = 4;
    localparam int unsigned DEF_ADDR_W   = 4;
    localparam int unsigned LANE_DUTY    = 0;
    localparam int unsigned LANE_DEAD    = 1;
    localparam int unsigned NUM_LANES    = 2;
    localparam int unsigned NUM_SIDES    = 2;
    localparam int unsigned SIDE_HI      = 0;
    localparam int unsigned SIDE_LO      = 1;
endpackage

// File: rtl/pwmdt_ctrl_reg.sv
// Live control register with per-lane write strobes.
// Holds the on-time and dead-time fields written by the processor.
// Assumes: at most one write per cycle; the address decode is a single match.
module pwmdt_ctrl_reg
    import pwmdt_pkg::*;
#(
    parameter int unsigned DUTY_W   = DEF_DUTY_W,
    parameter int unsigned DEAD_W   = DEF_DEAD_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned REG_ADDR = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NUM_LANES-1:0]     wr_strb,
    input  logic [DUTY_W+DEAD_W-1:0] wr_data,
    output logic [DUTY_W-1:0]        duty_o,
    output logic [DEAD_W-1:0]        dead_o
);
    localparam int unsigned         WORD_W   = DUTY_W + DEAD_W;
    localparam logic [ADDR_W-1:0]   HIT_ADDR = ADDR_W'(REG_ADDR);

    logic                wr_hit;
    logic [DUTY_W-1:0]   duty_q;
    logic [DEAD_W-1:0]   dead_q;

    // Purpose: decode a write aimed at this register.
    assign wr_hit = wr_en && (wr_addr == HIT_ADDR);

    // Purpose: update each field only when its own lane strobe is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            dead_q <= '0;
        end else begin
            if (wr_hit && wr_strb[LANE_DUTY]) begin
                duty_q <= wr_data[DUTY_W-1:0];
            end
            if (wr_hit && wr_strb[LANE_DEAD]) begin
                dead_q <= wr_data[WORD_W-1:DUTY_W];
            end
        end
    end

    assign duty_o = duty_q;
    assign dead_o = dead_q;

    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == HIT_ADDR && !wr_strb[LANE_DEAD]) |=> $stable(dead_o));

    // R2
    lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == HIT_ADDR && wr_strb[LANE_DUTY])
            |=> (duty_o == $past(wr_data[DUTY_W-1:0])));

    // R3
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != HIT_ADDR) |=> ($stable(duty_o) && $stable(dead_o)));
endmodule

// File: rtl/pwmdt_phase_gen.sv
// Period counter, shadow settings and raw pulse compare.
// The shadow registers reload from the live settings only on the last
// cycle of a period, so each period uses one consistent setting pair.
// Assumes: the period is 2**DUTY_W cycles and the all-ones on-time is full on.
module pwmdt_phase_gen
    import pwmdt_pkg::*;
#(
    parameter int unsigned DUTY_W = DEF_DUTY_W,
    parameter int unsigned DEAD_W = DEF_DEAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              raw_o,
    output logic [DEAD_W-1:0] dead_o
);
    localparam logic [DUTY_W-1:0] CNT_MAX = '1;
    localparam logic [DUTY_W-1:0] FULL_ON = '1;

    logic [DUTY_W-1:0] cnt_q;
    logic [DUTY_W-1:0] duty_sh_q;
    logic [DEAD_W-1:0] dead_sh_q;
    logic              wrap;

    // Purpose: flag the last phase of the period.
    assign wrap = (cnt_q == CNT_MAX);

    // Purpose: free-running phase counter, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: copy live settings into the shadow copy at the period edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_sh_q <= '0;
            dead_sh_q <= '0;
        end else if (wrap) begin
            duty_sh_q <= duty_i;
            dead_sh_q <= dead_i;
        end
    end

    // Purpose: raw pulse is high below the on-time, or always when full on.
    always_comb begin
        raw_o = (duty_sh_q == FULL_ON) || (cnt_q < duty_sh_q);
    end

    assign dead_o = dead_sh_q;

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> (cnt_q == DUTY_W'($past(cnt_q) + 1'b1)));

    // R4
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == '0));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> ($stable(duty_sh_q) && $stable(dead_sh_q)));
endmodule

// File: rtl/pwmdt_deadband.sv
// Dead-time insertion for a complementary output pair.
// Tracks how many cycles the registered raw pulse has held its level
// (saturating) and turns a side on only once that age reaches the
// dead time of the period the pulse came from.
// Assumes: raw_i and dead_i are produced from registered state upstream.
module pwmdt_deadband
    import pwmdt_pkg::*;
#(
    parameter int unsigned DEAD_W = DEF_DEAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              hi_o,
    output logic              lo_o
);
    localparam logic [DEAD_W-1:0] AGE_MAX = '1;

    logic                 raw_q;
    logic [DEAD_W-1:0]    age_q;
    logic [DEAD_W-1:0]    dead_q;
    logic                 settled;
    logic [NUM_SIDES-1:0] drive;

    // Purpose: register the raw pulse and the dead time it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            dead_q <= '0;
        end else begin
            raw_q  <= raw_i;
            dead_q <= dead_i;
        end
    end

    // Purpose: count cycles since the raw pulse last changed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (raw_i != raw_q) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Purpose: the level is old enough to be driven.
    assign settled = (age_q >= dead_q);

    // One registered output stage per side; the low side uses the inverted pulse.
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        logic level;
        logic side_q;
        assign level = (g == SIDE_HI) ? raw_q : !raw_q;
        // Purpose: drive this side only when its level has settled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                side_q <= 1'b0;
            end else begin
                side_q <= level && settled;
            end
        end
        assign drive[g] = side_q;
    end

    assign hi_o = drive[SIDE_HI];
    assign lo_o = drive[SIDE_LO];

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!hi_o && !lo_o));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    // R5
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lo_o) && $past(dead_q) != '0) |-> !hi_o);

    // R6
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi_o) && $past(dead_q) != '0) |-> !lo_o);

    // R9
    zero_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dead_q) == '0) |-> (hi_o != lo_o));
endmodule

// File: rtl/pwmdt_gen.sv
// Top level: register-controlled PWM generator with dead-time insertion.
// Chains the write register, the period/shadow stage and the dead-band
// stage. Outputs lag the phase compare by two clock cycles.
// Assumes: synchronous active-low reset held for at least one edge.
module pwmdt_gen
    import pwmdt_pkg::*;
#(
    parameter int unsigned DUTY_W   = DEF_DUTY_W,
    parameter int unsigned DEAD_W   = DEF_DEAD_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned REG_ADDR = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [1:0]               wr_strb,
    input  logic [DUTY_W+DEAD_W-1:0] wr_data,
    output logic                     pwm_hi,
    output logic                     pwm_lo
);
    logic [DUTY_W-1:0] live_duty;
    logic [DEAD_W-1:0] live_dead;
    logic              raw_pulse;
    logic [DEAD_W-1:0] period_dead;

    pwmdt_ctrl_reg #(
        .DUTY_W   (DUTY_W),
        .DEAD_W   (DEAD_W),
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .duty_o  (live_duty),
        .dead_o  (live_dead)
    );

    pwmdt_phase_gen #(
        .DUTY_W (DUTY_W),
        .DEAD_W (DEAD_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (live_duty),
        .dead_i (live_dead),
        .raw_o  (raw_pulse),
        .dead_o (period_dead)
    );

    pwmdt_deadband #(
        .DEAD_W (DEAD_W)
    ) u_band (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_pulse),
        .dead_i (period_dead),
        .hi_o   (pwm_hi),
        .lo_o   (pwm_lo)
    );
endmodule

// File: tb/pwmdt_gen_bench.sv
`timescale 1ns/1ps
module pwmdt_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_strb = '0;
    logic [11:0] wr_data = '0;
    logic        pwm_hi;
    logic        pwm_lo;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference model state (defaults: 8-bit on-time, 4-bit dead time).
    int m_cnt, m_duty, m_dead, m_dsh, m_tsh;
    bit h_raw [0:16];
    int h_dt  [0:16];
    bit h_val [0:16];

    always #4 clk = ~clk;  // 125 MHz

    pwmdt_gen u_pwmdt_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    task automatic check(input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, what, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_duty = 0; m_dead = 0; m_dsh = 0; m_tsh = 0;
        for (int j = 0; j <= 16; j++) begin
            h_raw[j] = 0; h_dt[j] = 0; h_val[j] = 0;
        end
        h_val[0] = 1;  // reset state acts as a low entry
    endtask

    // Advance the model by one clock edge with the inputs seen at that edge.
    task automatic model_edge();
        bit raw_c;
        if (!rst_n) begin
            model_reset();
            return;
        end
        raw_c = (m_dsh == 255) || (m_cnt < m_dsh);
        for (int j = 16; j > 0; j--) begin
            h_raw[j] = h_raw[j-1]; h_dt[j] = h_dt[j-1]; h_val[j] = h_val[j-1];
        end
        h_raw[0] = raw_c; h_dt[0] = m_tsh; h_val[0] = 1;
        if (m_cnt == 255) begin
            m_dsh = m_duty; m_tsh = m_dead;
        end
        if (wr_en && wr_addr == 4'd0) begin
            if (wr_strb[0]) m_duty = int'(wr_data[7:0]);
            if (wr_strb[1]) m_dead = int'(wr_data[11:8]);
        end
        m_cnt = (m_cnt + 1) % 256;
    endtask

    task automatic compare();
        bit eh, el, on;
        int age;
        eh = 0; el = 0;
        if (h_val[1]) begin
            age = 0;
            for (int j = 2; j <= 16; j++) begin
                if (!(h_val[j] && h_raw[j] == h_raw[1])) break;
                age++;
            end
            on = (age >= h_dt[1]);
            eh = h_raw[1] && on;
            el = !h_raw[1] && on;
        end
        check(pwm_hi, eh, "high side");
        check(pwm_lo, el, "low side");
        // R7: never both on
        check(pwm_hi && pwm_lo, 1'b0, "R7 overlap");
        // R9: exact complement with zero dead time
        if (h_val[1] && h_val[2] && h_dt[1] == 0)
            check(pwm_hi ^ pwm_lo, 1'b1, "R9 complement");
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
        cycle();
        wr_en = 1'b0; wr_strb = '0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        tag = "R1";
        run(3);
        rst_n = 1'b1;
        run(4);

        tag = "R2";  // full word: dead 5, on-time 64
        wr(4'd0, 2'b11, {4'd5, 8'd64});
        run(600);
        tag = "R2";  // on-time lane only; dead field data must be ignored
        wr(4'd0, 2'b01, {4'hA, 8'd200});
        run(600);
        wr(4'd0, 2'b10, {4'd2, 8'h11});
        run(600);

        tag = "R3";
        wr(4'd3, 2'b11, {4'd9, 8'd7});
        run(600);

        tag = "R5 R6";
        for (int d = 0; d < 16; d++) begin
            wr(4'd0, 2'b11, {4'(d), 8'd100});
            run(300);
        end

        tag = "R4";
        for (int du = 0; du < 256; du++) begin
            wr(4'd0, 2'b11, {4'(du % 16), 8'(du)});
            run(256);
        end
        wr(4'd0, 2'b11, {4'd15, 8'd0});   run(600);
        wr(4'd0, 2'b11, {4'd15, 8'd255}); run(600);
        wr(4'd0, 2'b11, {4'd15, 8'd254}); run(600);
        wr(4'd0, 2'b11, {4'd15, 8'd1});   run(600);
        wr(4'd0, 2'b11, {4'd0, 8'd255});  run(600);

        tag = "R8";
        begin
            int seed;
            seed = 12345;
            for (int i = 0; i < 60; i++) begin
                seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
                wr(4'd0, 2'(seed % 3 + 1), 12'(seed >> 7));
                run(37 + (i * 13) % 100);
            end
            run(600);
        end

        tag = "R1";
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        run(300);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule